// File: doc/BRIEF.md
# Parallel-to-tester lane bridge with pin loopback

This block carries a wide data word, produced once per slow (40 MHz) cycle, to an external IC tester over a narrow bank of single-ended pins toggling at four times that rate. The word is split into 4-bit groups, one group per data lane. Each lane sends its group over four fast-clock slots, most significant bit first. A companion lane pulses once per word so that the tester can find word boundaries. One further pin gives a static "everything is up" level, formed from the clock-synthesis and recovery status flags.

The block runs entirely in the fast (160 MHz) domain. The slow word is taken to be held stable for four fast cycles. Synchronous reset is released on the fast edge that follows a slow edge. From then on, a free-running phase counter marks the first fast cycle of each slow period, and the word is captured in that cycle. A loopback mode, chosen by a debug bit or by a switch input that reads low when closed, bypasses everything. In that mode each tester input pin is wired straight to the matching tester output pin, with no register in the path, for pin-level continuity tests.

Top module: `tester_bridge`

## Requirements
- R1: The word on `word_in` is captured only in the fast cycle whose phase counter is 0. Changes to `word_in` during the other three slots have no effect on the lanes until the next capture.
- R2: With loopback off, data lane i (`tst_out[i]`, i = 0..28) shows word bits 4i+3, 4i+2, 4i+1 and 4i in the four fast cycles after the capture edge, in that order.
- R3: With loopback off, the marker pin `tst_out[29]` is 1 in exactly the slot that carries bits 4i+3 (the first slot after capture) and 0 in the other three slots.
- R4: With loopback off, `tst_out[30]` is the combinational OR of every `pll_locked` bit, every `pll_ready` bit and `cdr_valid`.
- R5: When loopback is active, `tst_out[k]` equals `tst_in[k]` for all 31 pins in the same cycle, with no clock edge in between. This also holds during reset.
- R6: Loopback is active exactly when `dbg_loop` is 1 or `dip_loop_raw` is 0.
- R7: While `rst` is 1 with loopback off, pins 0..29 are 0 and the phase counter is held at 0. The first fast edge after release captures the word present at that edge, and it is slot 0 (marker high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | 160 MHz clock, phase-aligned to the word clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 116 | Data word, stable for four fast cycles |
| pll_locked | input | 2 | Lock flags of the clock synthesizers |
| pll_ready | input | 2 | Ready flags of the clock synthesizers |
| cdr_valid | input | 1 | Data-valid flag standing in for recovery-ready |
| dbg_loop | input | 1 | Debug-register loopback request, active high |
| dip_loop_raw | input | 1 | Raw switch level; 0 requests loopback |
| tst_in | input | 31 | Pins driven by the tester |
| tst_out | output | 31 | Pins to the tester: [28:0] data, [29] marker, [30] readiness |

## Verification
The serializer is driven with all-zero and all-one words, alternating 0xA and 0x5 nibbles, a counting-nibble word, a word with only the top bit set, and a word whose nibbles all equal 0x8. Uniform words reveal stuck lanes. The alternating and counting words reveal lane or slot swaps, and a reversed bit order within a slot. The single-bit and 0x8 words pin down the most-significant-first order and lane 28's position. In every word, the input is inverted right after capture, which tells a holding register apart from a direct feed-through. The readiness pin is tried with each status flag set alone and with none set, and loopback is tried from each control source, with opposing pin patterns and also during reset.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  localparam int unsigned DEF_LANES = 29;
  localparam int unsigned DEF_SLOTS = 4;
  localparam int unsigned DEF_NPLL  = 2;

  function automatic int unsigned cnt_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tbr_phase.sv
module tbr_phase #(
  parameter int unsigned SLOTS = tbr_pkg::DEF_SLOTS
) (
  input  logic clk,
  input  logic rst,
  output logic load_o,
  output logic mark_o
);
  localparam int unsigned CW = tbr_pkg::cnt_w(SLOTS);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  logic [CW-1:0] cnt_q;
  logic          mark_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mark_q <= 1'b0;
    end else begin
      mark_q <= (cnt_q == '0);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  end

  assign load_o = (cnt_q == '0);
  assign mark_o = mark_q;
endmodule

// File: rtl/tbr_lane_ser.sv
module tbr_lane_ser #(
  parameter int unsigned SLOTS = tbr_pkg::DEF_SLOTS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [SLOTS-1:0] grp_i,
  output logic             bit_o
);
  logic [SLOTS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)         sh_q <= '0;
    else if (load_i) sh_q <= grp_i;
    else             sh_q <= sh_q << 1;
  end

  assign bit_o = sh_q[SLOTS-1];
endmodule

// File: rtl/tbr_ready_or.sv
module tbr_ready_or #(
  parameter int unsigned NPLL = tbr_pkg::DEF_NPLL
) (
  input  logic [NPLL-1:0] lock_i,
  input  logic [NPLL-1:0] rdy_i,
  input  logic            cdr_i,
  output logic            up_o
);
  assign up_o = (|lock_i) | (|rdy_i) | cdr_i;
endmodule

// File: rtl/tbr_pin_mux.sv
module tbr_pin_mux #(
  parameter int unsigned PINS = tbr_pkg::DEF_LANES + 2
) (
  input  logic            dbg_i,
  input  logic            dip_raw_i,
  input  logic [PINS-1:0] core_i,
  input  logic [PINS-1:0] tin_i,
  output logic [PINS-1:0] pins_o
);
  logic loop;
  assign loop   = dbg_i | ~dip_raw_i;
  assign pins_o = loop ? tin_i : core_i;
endmodule

// File: rtl/tester_bridge.sv
module tester_bridge #(
  parameter int unsigned LANES = tbr_pkg::DEF_LANES,
  parameter int unsigned SLOTS = tbr_pkg::DEF_SLOTS,
  parameter int unsigned NPLL  = tbr_pkg::DEF_NPLL,
  localparam int unsigned WW   = LANES * SLOTS,
  localparam int unsigned PINS = LANES + 2
) (
  input  logic            clk_fast,
  input  logic            rst,
  input  logic [WW-1:0]   word_in,
  input  logic [NPLL-1:0] pll_locked,
  input  logic [NPLL-1:0] pll_ready,
  input  logic            cdr_valid,
  input  logic            dbg_loop,
  input  logic            dip_loop_raw,
  input  logic [PINS-1:0] tst_in,
  output logic [PINS-1:0] tst_out
);
  logic             load;
  logic             mark;
  logic             up;
  logic [LANES-1:0] lane_bits;

  tbr_phase #(.SLOTS(SLOTS)) phase_i (
    .clk(clk_fast), .rst(rst), .load_o(load), .mark_o(mark)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tbr_lane_ser #(.SLOTS(SLOTS)) ser_i (
      .clk(clk_fast), .rst(rst), .load_i(load),
      .grp_i(word_in[i*SLOTS +: SLOTS]), .bit_o(lane_bits[i])
    );
  end

  tbr_ready_or #(.NPLL(NPLL)) ready_i (
    .lock_i(pll_locked), .rdy_i(pll_ready), .cdr_i(cdr_valid), .up_o(up)
  );

  tbr_pin_mux #(.PINS(PINS)) mux_i (
    .dbg_i(dbg_loop), .dip_raw_i(dip_loop_raw),
    .core_i({up, mark, lane_bits}), .tin_i(tst_in), .pins_o(tst_out)
  );
endmodule

// File: rtl/tbr_chk.sv
module tbr_chk #(
  parameter int unsigned LANES = 29,
  parameter int unsigned SLOTS = 4,
  parameter int unsigned NPLL  = 2
) (
  input logic                 clk_fast,
  input logic                 rst,
  input logic [NPLL-1:0]      pll_locked,
  input logic [NPLL-1:0]      pll_ready,
  input logic                 cdr_valid,
  input logic                 dbg_loop,
  input logic                 dip_loop_raw,
  input logic [LANES+1:0]     tst_in,
  input logic [LANES+1:0]     tst_out
);
  localparam int unsigned CW = tbr_pkg::cnt_w(SLOTS);
  logic          lp;
  logic [CW-1:0] pc_q;
  logic          rst_d;

  assign lp = dbg_loop | ~dip_loop_raw;

  always_ff @(posedge clk_fast) begin
    rst_d <= rst;
    if (rst) pc_q <= '0;
    else     pc_q <= (pc_q == CW'(SLOTS - 1)) ? '0 : pc_q + CW'(1);
  end

  // R7
  always_ff @(posedge clk_fast) begin
    if (rst_d && rst && !lp)
      reset_low_chk: assert (tst_out[LANES:0] == '0);
  end

  // R5
  loop_copy_chk: assert property (@(posedge clk_fast) lp |-> tst_out == tst_in);

  // R4
  ready_lvl_chk: assert property (@(posedge clk_fast) disable iff (rst)
    !lp |-> tst_out[LANES+1] == ((|pll_locked) | (|pll_ready) | cdr_valid));

  // R3
  mark_slot_chk: assert property (@(posedge clk_fast) disable iff (rst)
    !lp |-> tst_out[LANES] == (pc_q == CW'(1)));

  // R3
  mark_single_chk: assert property (@(posedge clk_fast) disable iff (rst)
    (!lp && tst_out[LANES]) |=> (lp || !tst_out[LANES]));
endmodule

bind tester_bridge tbr_chk #(.LANES(LANES), .SLOTS(SLOTS), .NPLL(NPLL)) chk_i (
  .clk_fast(clk_fast), .rst(rst), .pll_locked(pll_locked), .pll_ready(pll_ready),
  .cdr_valid(cdr_valid), .dbg_loop(dbg_loop), .dip_loop_raw(dip_loop_raw),
  .tst_in(tst_in), .tst_out(tst_out)
);

// File: tb/tester_bridge_tb_top.sv
module tester_bridge_tb_top;
  localparam int WW = 116;
  localparam logic [WW-1:0] VEC [7] = '{
    {WW{1'b0}},
    {WW{1'b1}},
    {29{4'hA}},
    {29{4'h5}},
    116'h0123456789ABCDEF0123456789A,
    {1'b1, 115'b0},
    {29{4'h8}}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [WW-1:0] word_in = '1;
  logic [1:0]    pll_locked = '0;
  logic [1:0]    pll_ready = '0;
  logic          cdr_valid = 1'b0;
  logic          dbg_loop = 1'b0;
  logic          dip_loop_raw = 1'b1;
  logic [30:0]   tst_in = '0;
  logic [30:0]   tst_out;
  int            n_chk = 0;
  int            n_fail = 0;

  always #10 clk = ~clk;

  tester_bridge dut_i (
    .clk_fast(clk), .rst(rst), .word_in(word_in), .pll_locked(pll_locked),
    .pll_ready(pll_ready), .cdr_valid(cdr_valid), .dbg_loop(dbg_loop),
    .dip_loop_raw(dip_loop_raw), .tst_in(tst_in), .tst_out(tst_out)
  );

  task automatic chk(string tag, logic [30:0] act, logic [30:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [28:0] slot_bits(logic [WW-1:0] w, int s);
    logic [28:0] e;
    for (int i = 0; i < 29; i++) e[i] = w[4*i + 3 - s];
    return e;
  endfunction

  // Called at a negedge whose next posedge is a capture edge.
  task automatic send_word(logic [WW-1:0] w, string tag);
    word_in = w;
    for (int s = 0; s < 4; s++) begin
      @(posedge clk); @(negedge clk);
      if (s == 0) word_in = ~w;  // R1: later changes must not reach lanes
      chk({tag, " R1 R2 lanes"}, {2'b0, tst_out[28:0]}, {2'b0, slot_bits(w, s)});
      chk({tag, " R3 marker"}, {30'b0, tst_out[29]}, {30'b0, (s == 0)});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset holds lanes and marker low, R4 with nothing up
    chk("R7 reset low", {1'b0, tst_out[29:0]}, 31'b0);
    chk("R4 none up", {30'b0, tst_out[30]}, 31'b0);
    rst = 1'b0;
    foreach (VEC[v]) send_word(VEC[v], "R2 vector");

    // R4: each flag alone raises the readiness pin
    pll_locked = 2'b10; #1 chk("R4 lock1", {30'b0, tst_out[30]}, 31'd1);
    pll_locked = 2'b00; pll_ready = 2'b01; #1 chk("R4 rdy0", {30'b0, tst_out[30]}, 31'd1);
    pll_ready = 2'b00; cdr_valid = 1'b1; #1 chk("R4 cdr", {30'b0, tst_out[30]}, 31'd1);
    cdr_valid = 1'b0; #1 chk("R4 off", {30'b0, tst_out[30]}, 31'd0);

    // R5 R6: loopback from the debug bit, same cycle
    @(negedge clk);
    tst_in = 31'h2AAA_AAAA; dbg_loop = 1'b1;
    #1 chk("R5 R6 dbg loop", tst_out, 31'h2AAA_AAAA);
    tst_in = 31'h5555_5555;
    #1 chk("R5 comb copy", tst_out, 31'h5555_5555);
    // R6: switch closed (raw 0) also loops
    dbg_loop = 1'b0; dip_loop_raw = 1'b0; tst_in = 31'h7FFF_FFFF;
    #1 chk("R6 dip loop", tst_out, 31'h7FFF_FFFF);
    // R6: neither source -> no loop; readiness pin shows status 0
    dip_loop_raw = 1'b1;
    #1 chk("R6 no loop", {30'b0, tst_out[30]}, 31'd0);

    // R5: loopback also during reset
    @(negedge clk); rst = 1'b1; dbg_loop = 1'b1; tst_in = 31'h1234_5678;
    @(posedge clk); @(negedge clk);
    chk("R5 loop in reset", tst_out, 31'h1234_5678);
    dbg_loop = 1'b0;
    #1 chk("R7 reset low mid-run", {1'b0, tst_out[29:0]}, 31'b0);

    // R7: realignment after a mid-stream reset
    @(negedge clk); rst = 1'b0;
    send_word(VEC[4], "R7 first word");
    send_word(VEC[2], "R7 second word");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL R7 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule